// File: doc/BRIEF.md
# Phase-Cycled Quadrature Scan Accumulator

This block sums complex samples over repeated scans. Each sample carries a 14-bit two's-complement real part and a 14-bit two's-complement imaginary part, plus the index of the point it belongs to. For every accepted sample the block reads the stored 32-bit real and 32-bit imaginary sums for that point from an external memory. It combines them with the sample and writes the result back to the same point.

A 30-bit pattern word holds up to ten 3-bit lines, and a separate line count sets how many of those lines are in use. One line applies per scan. The line can exchange the two input channels and can subtract, rather than add, either part. Successive scans step through the lines in order, so phase cycling happens without help from software. The first scan after an experiment clear does not accumulate: it overwrites memory. A scan counter caps the number of scans. A sample that arrives while the previous read-modify-write is still in flight is dropped and raises a sticky error flag.

Top module: `qavg_engine`

## Requirements
- R1: After reset the scan count, line index and error flag read 0, and neither memory read nor memory write is asserted.
- R2: On the first scan after a clear, the value read back is ignored. The written sums are 0 plus or minus the sign-extended inputs, as chosen by the scan's line.
- R3: On later scans, line bit 1 set means the real sum is the read-back real minus the extended real input; clear means it is plus. Line bit 0 chooses the same for the imaginary part.
- R4: Line bit 2 set exchanges the channels: the real sum takes the imaginary input and the imaginary sum takes the real input.
- R5: The first scan after a clear uses line 0. Each later scan uses the next line and wraps to line 0 after line_count-1. Line k is pattern bits [3k+2:3k], and its index is shown on line_idx_o.
- R6: A line count of 0 acts as 1. A line count above 10 acts as 10.
- R7: The line applied to a scan is taken from the pattern at scan start. Later pattern or count changes do not affect that scan's samples.
- R8: An accepted sample raises mem_rd_o at smp_idx_i in the same cycle. mem_we_o follows RD_LAT+1 cycles later at the same index and is high for one cycle.
- R9: A valid sample arriving while an earlier one has not yet been written is dropped, with no read and no write. It sets ovr_err_o, which stays set until a clear.
- R10: The scan count rises by one per scan start up to MAX_SCANS. Further scan starts leave the count and line unchanged.
- R11: Samples arriving while the scan count is 0 are ignored.
- R12: Sums wrap modulo 2^32.
- R13: exp_clear_i zeroes the scan count and the error flag, so the next scan is a first scan on line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exp_clear_i | input | 1 | Start a new experiment |
| scan_start_i | input | 1 | Begin a scan (one-cycle pulse) |
| pattern_i | input | 30 | Ten 3-bit lines, line k at [3k+2:3k] |
| line_count_i | input | 4 | Number of lines in use |
| scan_cnt_o | output | CNT_W | Scans begun since clear |
| line_idx_o | output | 4 | Line index of the current scan |
| smp_valid_i | input | 1 | Sample strobe |
| smp_re_i | input | 14 | Real input, two's complement |
| smp_im_i | input | 14 | Imaginary input, two's complement |
| smp_idx_i | input | ADDR_W | Point index |
| mem_rd_o | output | 1 | Memory read enable |
| mem_raddr_o | output | ADDR_W | Read address |
| mem_rdata_re_i | input | 32 | Stored real sum, RD_LAT cycles after read |
| mem_rdata_im_i | input | 32 | Stored imaginary sum |
| mem_we_o | output | 1 | Memory write enable |
| mem_waddr_o | output | ADDR_W | Write address |
| mem_wdata_re_o | output | 32 | Real sum to store |
| mem_wdata_im_o | output | 32 | Imaginary sum to store |
| ovr_err_o | output | 1 | Sticky overrun flag |

## Verification
A wrong line index shows on line_idx_o in the cycle after the scan start. It also shows as a wrong sign or a swapped part in the next written point, RD_LAT+1 cycles after that sample. A stale first-scan flag appears as garbage accumulated into a preloaded point instead of an overwrite. A broken busy window appears as a second read or write while one is in flight, or as a missing ovr_err_o one cycle after the colliding strobe. A bad counter limit appears when a scan start at the cap moves scan_cnt_o.

// File: rtl/qavg_pkg.sv
package qavg_pkg;
  localparam int SMP_W     = 14;
  localparam int ACC_W     = 32;
  localparam int LINE_W    = 3;
  localparam int MAX_LINES = 10;
  localparam int PAT_W     = LINE_W * MAX_LINES;
  localparam int LIDX_W    = $clog2(MAX_LINES + 1);

  typedef struct packed {
    logic swap;
    logic re_sub;
    logic im_sub;
  } line_t;
endpackage

// File: rtl/qavg_combine.sv
module qavg_combine
  import qavg_pkg::*;
(
  input  logic [SMP_W-1:0] re_i,
  input  logic [SMP_W-1:0] im_i,
  input  line_t            line_i,
  input  logic             first_i,
  input  logic [ACC_W-1:0] base_re_i,
  input  logic [ACC_W-1:0] base_im_i,
  output logic [ACC_W-1:0] sum_re_o,
  output logic [ACC_W-1:0] sum_im_o
);
  localparam int EXT_W = ACC_W - SMP_W;

  logic [SMP_W-1:0] sel_re, sel_im;
  logic [ACC_W-1:0] ext_re, ext_im, acc_re, acc_im;

  always_comb begin
    sel_re = line_i.swap ? im_i : re_i;
    sel_im = line_i.swap ? re_i : im_i;
    ext_re = {{EXT_W{sel_re[SMP_W-1]}}, sel_re};
    ext_im = {{EXT_W{sel_im[SMP_W-1]}}, sel_im};
    // first scan discards the read-back value
    acc_re = first_i ? '0 : base_re_i;
    acc_im = first_i ? '0 : base_im_i;
    sum_re_o = line_i.re_sub ? (acc_re - ext_re) : (acc_re + ext_re);
    sum_im_o = line_i.im_sub ? (acc_im - ext_im) : (acc_im + ext_im);
  end
endmodule

// File: rtl/qavg_scan_ctrl.sv
module qavg_scan_ctrl
  import qavg_pkg::*;
#(
  parameter int MAX_SCANS = 262144,
  parameter int CNT_W     = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [LIDX_W-1:0] line_count_i,
  output logic [CNT_W-1:0]  scan_cnt_o,
  output logic [LIDX_W-1:0] line_idx_o,
  output line_t             line_o,
  output logic              first_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = CNT_W'(MAX_SCANS);
  localparam logic [LIDX_W-1:0] LINE_MAX = LIDX_W'(MAX_LINES);

  line_t             lines [MAX_LINES];
  logic [CNT_W-1:0]  cnt_q;
  logic [LIDX_W-1:0] idx_q, eff_cnt, nxt_idx;
  line_t             line_q;
  logic              first_q, take;

  for (genvar k = 0; k < MAX_LINES; k++) begin : g_line
    assign lines[k] = line_t'(pattern_i[k*LINE_W +: LINE_W]);
  end

  always_comb begin
    if (line_count_i == '0)          eff_cnt = LIDX_W'(1);
    else if (line_count_i > LINE_MAX) eff_cnt = LINE_MAX;
    else                              eff_cnt = line_count_i;
  end

  always_comb begin
    if (cnt_q == '0)                            nxt_idx = '0;
    else if ((idx_q + LIDX_W'(1)) >= eff_cnt)   nxt_idx = '0;
    else                                        nxt_idx = idx_q + LIDX_W'(1);
  end

  assign take = start_i && (cnt_q != CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      line_q  <= '0;
      first_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= cnt_q + CNT_W'(1);
      idx_q   <= nxt_idx;
      line_q  <= lines[nxt_idx];
      first_q <= (cnt_q == '0);
    end
  end

  assign scan_cnt_o = cnt_q;
  assign line_idx_o = idx_q;
  assign line_o     = line_q;
  assign first_o    = first_q;

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  assert_cnt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clear_i) |=> (cnt_q == CNT_MAX));
  assert_line_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < LINE_MAX);
  assert_first_line0_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cnt_q == '0 && !clear_i) |=> (idx_q == '0 && first_q));
endmodule

// File: rtl/qavg_rmw_pipe.sv
module qavg_rmw_pipe
  import qavg_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int RD_LAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              active_i,
  input  line_t             line_i,
  input  logic              first_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_re_i,
  input  logic [SMP_W-1:0]  smp_im_i,
  input  logic [ADDR_W-1:0] smp_idx_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [ACC_W-1:0]  mem_rdata_re_i,
  input  logic [ACC_W-1:0]  mem_rdata_im_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [ACC_W-1:0]  mem_wdata_re_o,
  output logic [ACC_W-1:0]  mem_wdata_im_o,
  output logic              ovr_err_o
);
  typedef struct packed {
    logic [SMP_W-1:0]  re;
    logic [SMP_W-1:0]  im;
    logic [ADDR_W-1:0] idx;
    line_t             line;
    logic              first;
  } stage_t;

  stage_t            stg_q [RD_LAT];
  logic              vld_q [RD_LAT];
  stage_t            in_stg;
  logic              busy, accept, we_q, err_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [ACC_W-1:0]  wre_q, wim_q, sum_re, sum_im;

  always_comb begin
    busy = we_q;
    for (int k = 0; k < RD_LAT; k++) busy |= vld_q[k];
  end

  assign accept = smp_valid_i && active_i && !busy;
  assign in_stg = '{re: smp_re_i, im: smp_im_i, idx: smp_idx_i, line: line_i, first: first_i};

  for (genvar k = 0; k < RD_LAT; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[0] <= 1'b0;
          stg_q[0] <= '0;
        end else begin
          vld_q[0] <= accept;
          if (accept) stg_q[0] <= in_stg;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          vld_q[k] <= 1'b0;
          stg_q[k] <= '0;
        end else begin
          vld_q[k] <= vld_q[k-1];
          if (vld_q[k-1]) stg_q[k] <= stg_q[k-1];
        end
      end
    end
  end

  qavg_combine i_combine (
    .re_i      (stg_q[RD_LAT-1].re),
    .im_i      (stg_q[RD_LAT-1].im),
    .line_i    (stg_q[RD_LAT-1].line),
    .first_i   (stg_q[RD_LAT-1].first),
    .base_re_i (mem_rdata_re_i),
    .base_im_i (mem_rdata_im_i),
    .sum_re_o  (sum_re),
    .sum_im_o  (sum_im)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wre_q   <= '0;
      wim_q   <= '0;
    end else begin
      we_q <= vld_q[RD_LAT-1];
      if (vld_q[RD_LAT-1]) begin
        waddr_q <= stg_q[RD_LAT-1].idx;
        wre_q   <= sum_re;
        wim_q   <= sum_im;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              err_q <= 1'b0;
    else if (clear_i)                         err_q <= 1'b0;
    else if (smp_valid_i && active_i && busy) err_q <= 1'b1;
  end

  assign mem_rd_o       = accept;
  assign mem_raddr_o    = smp_idx_i;
  assign mem_we_o       = we_q;
  assign mem_waddr_o    = waddr_q;
  assign mem_wdata_re_o = wre_q;
  assign mem_wdata_im_o = wim_q;
  assign ovr_err_o      = err_q;

  assert_we_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !clear_i) |=> ovr_err_o);
  assert_no_rd_during_we_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_rd_o);
endmodule

// File: rtl/qavg_engine.sv
module qavg_engine
  import qavg_pkg::*;
#(
  parameter  int ADDR_W    = 9,
  parameter  int RD_LAT    = 1,
  parameter  int MAX_SCANS = 262144,
  localparam int CNT_W     = $clog2(MAX_SCANS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exp_clear_i,
  input  logic              scan_start_i,
  input  logic [PAT_W-1:0]  pattern_i,
  input  logic [LIDX_W-1:0] line_count_i,
  output logic [CNT_W-1:0]  scan_cnt_o,
  output logic [LIDX_W-1:0] line_idx_o,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_re_i,
  input  logic [SMP_W-1:0]  smp_im_i,
  input  logic [ADDR_W-1:0] smp_idx_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [ACC_W-1:0]  mem_rdata_re_i,
  input  logic [ACC_W-1:0]  mem_rdata_im_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [ACC_W-1:0]  mem_wdata_re_o,
  output logic [ACC_W-1:0]  mem_wdata_im_o,
  output logic              ovr_err_o
);
  line_t cur_line;
  logic  cur_first, scan_active;

  qavg_scan_ctrl #(.MAX_SCANS(MAX_SCANS), .CNT_W(CNT_W)) i_scan_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (exp_clear_i),
    .start_i      (scan_start_i),
    .pattern_i    (pattern_i),
    .line_count_i (line_count_i),
    .scan_cnt_o   (scan_cnt_o),
    .line_idx_o   (line_idx_o),
    .line_o       (cur_line),
    .first_o      (cur_first)
  );

  assign scan_active = (scan_cnt_o != '0);

  qavg_rmw_pipe #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) i_rmw_pipe (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (exp_clear_i),
    .active_i       (scan_active),
    .line_i         (cur_line),
    .first_i        (cur_first),
    .smp_valid_i    (smp_valid_i),
    .smp_re_i       (smp_re_i),
    .smp_im_i       (smp_im_i),
    .smp_idx_i      (smp_idx_i),
    .mem_rd_o       (mem_rd_o),
    .mem_raddr_o    (mem_raddr_o),
    .mem_rdata_re_i (mem_rdata_re_i),
    .mem_rdata_im_i (mem_rdata_im_i),
    .mem_we_o       (mem_we_o),
    .mem_waddr_o    (mem_waddr_o),
    .mem_wdata_re_o (mem_wdata_re_o),
    .mem_wdata_im_o (mem_wdata_im_o),
    .ovr_err_o      (ovr_err_o)
  );

  assert_rd_needs_scan_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> (scan_cnt_o != '0));
endmodule

// File: tb/test_qavg_engine.sv
module test_qavg_engine;
  localparam int ADDR_W = 4;
  localparam int RD_LAT = 1;
  localparam int MAX_SC = 12;
  localparam int NPT    = 16;
  localparam int CW     = $clog2(MAX_SC + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic exp_clear_i = 1'b0, scan_start_i = 1'b0, smp_valid_i = 1'b0;
  logic [29:0] pattern_i = '0;
  logic [3:0]  line_count_i = '0;
  logic [13:0] smp_re_i = '0, smp_im_i = '0;
  logic [ADDR_W-1:0] smp_idx_i = '0;
  logic [CW-1:0] scan_cnt_o;
  logic [3:0] line_idx_o;
  logic mem_rd_o, mem_we_o, ovr_err_o;
  logic [ADDR_W-1:0] mem_raddr_o, mem_waddr_o;
  logic [31:0] rd_re, rd_im, mem_wdata_re_o, mem_wdata_im_o;

  logic [31:0] mem_re [NPT];
  logic [31:0] mem_im [NPT];
  logic [31:0] exp_re [NPT];
  logic [31:0] exp_im [NPT];
  logic pre_we = 1'b0;
  logic [ADDR_W-1:0] pre_addr = '0;
  logic [31:0] pre_re = '0, pre_im = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qavg_engine #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT), .MAX_SCANS(MAX_SC)) i_qavg_engine (
    .clk_i(clk), .rst_ni(rst_ni), .exp_clear_i(exp_clear_i), .scan_start_i(scan_start_i),
    .pattern_i(pattern_i), .line_count_i(line_count_i), .scan_cnt_o(scan_cnt_o),
    .line_idx_o(line_idx_o), .smp_valid_i(smp_valid_i), .smp_re_i(smp_re_i),
    .smp_im_i(smp_im_i), .smp_idx_i(smp_idx_i), .mem_rd_o(mem_rd_o),
    .mem_raddr_o(mem_raddr_o), .mem_rdata_re_i(rd_re), .mem_rdata_im_i(rd_im),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_re_o(mem_wdata_re_o),
    .mem_wdata_im_o(mem_wdata_im_o), .ovr_err_o(ovr_err_o)
  );

  // bench memory, one-cycle synchronous read
  always_ff @(posedge clk) begin
    if (mem_rd_o) begin
      rd_re <= mem_re[mem_raddr_o];
      rd_im <= mem_im[mem_raddr_o];
    end
    if (pre_we) begin
      mem_re[pre_addr] <= pre_re;
      mem_im[pre_addr] <= pre_im;
    end else if (mem_we_o) begin
      mem_re[mem_waddr_o] <= mem_wdata_re_o;
      mem_im[mem_waddr_o] <= mem_wdata_im_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] sx(input logic [13:0] v);
    return {{18{v[13]}}, v};
  endfunction

  task automatic preload(input int idx, input logic [31:0] re, input logic [31:0] im);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = ADDR_W'(idx); pre_re = re; pre_im = im;
    @(negedge clk);
    pre_we = 1'b0;
    exp_re[idx] = re; exp_im[idx] = im;
  endtask

  task automatic do_clear();
    @(negedge clk); exp_clear_i = 1'b1;
    @(negedge clk); exp_clear_i = 1'b0;
  endtask

  task automatic scan(input logic [29:0] pat, input logic [3:0] lc,
                      input int eidx, input int ecnt, input string req);
    @(negedge clk);
    pattern_i = pat; line_count_i = lc; scan_start_i = 1'b1;
    @(negedge clk);
    scan_start_i = 1'b0;
    chk({req, " line"}, 32'(line_idx_o), 32'(eidx));
    chk({req, " count"}, 32'(scan_cnt_o), 32'(ecnt));
  endtask

  task automatic smp(input int idx, input logic [13:0] re, input logic [13:0] im,
                     input logic [2:0] ln, input bit first, input bit timed, input string req);
    logic [13:0] a_re, a_im;
    logic [31:0] b_re, b_im;
    a_re = ln[2] ? im : re;
    a_im = ln[2] ? re : im;
    b_re = first ? 32'h0 : exp_re[idx];
    b_im = first ? 32'h0 : exp_im[idx];
    exp_re[idx] = ln[1] ? b_re - sx(a_re) : b_re + sx(a_re);
    exp_im[idx] = ln[0] ? b_im - sx(a_im) : b_im + sx(a_im);
    @(negedge clk);
    smp_valid_i = 1'b1; smp_idx_i = ADDR_W'(idx); smp_re_i = re; smp_im_i = im;
    if (timed) begin
      #1;
      chk("R8 read same cycle", 32'(mem_rd_o), 32'd1);
      chk("R8 read addr", 32'(mem_raddr_o), 32'(idx));
    end
    @(negedge clk);
    smp_valid_i = 1'b0;
    if (timed) chk("R8 no early write", 32'(mem_we_o), 32'd0);
    @(negedge clk);
    if (timed) begin
      chk("R8 write at RD_LAT+1", 32'(mem_we_o), 32'd1);
      chk("R8 write addr", 32'(mem_waddr_o), 32'(idx));
    end
    @(negedge clk);
    if (timed) chk("R8 write one cycle", 32'(mem_we_o), 32'd0);
    chk({req, " re"}, mem_re[idx], exp_re[idx]);
    chk({req, " im"}, mem_im[idx], exp_im[idx]);
  endtask

  localparam logic [29:0] PAT4 = {18'b0, 3'b101, 3'b011, 3'b110, 3'b000};

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 count", 32'(scan_cnt_o), 0);
    chk("R1 line", 32'(line_idx_o), 0);
    chk("R1 err", 32'(ovr_err_o), 0);
    chk("R1 we", 32'(mem_we_o), 0);
    chk("R1 rd", 32'(mem_rd_o), 0);
    for (int i = 0; i < NPT; i++) preload(i, 32'h0, 32'h0);
  endtask

  task automatic t_presample();
    preload(2, 32'h11111111, 32'h22222222);
    @(negedge clk);
    smp_valid_i = 1'b1; smp_idx_i = 2; smp_re_i = 14'd9; smp_im_i = 14'd9;
    #1 chk("R11 no read", 32'(mem_rd_o), 0);
    @(negedge clk); smp_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 mem re kept", mem_re[2], 32'h11111111);
    chk("R11 mem im kept", mem_im[2], 32'h22222222);
  endtask

  task automatic t_first_and_accum();
    preload(0, 32'hDEADBEEF, 32'hCAFEF00D);
    preload(1, 32'h55555555, 32'h66666666);
    scan(PAT4, 4'd4, 0, 1, "R5 scan1");
    smp(0, 14'd100, 14'h3FFB, 3'b000, 1, 0, "R2 first");
    smp(1, 14'h1FFF, 14'h2000, 3'b000, 1, 0, "R2 extremes");
    smp(2, 14'd0, 14'd1, 3'b000, 1, 0, "R2 overwrite");
    smp(3, 14'h3FFF, 14'd7, 3'b000, 1, 0, "R2 neg");
    scan(PAT4, 4'd4, 1, 2, "R5 scan2");
    smp(0, 14'd3, 14'd50, 3'b110, 0, 0, "R4 swap resub");
    smp(1, 14'h2000, 14'd1, 3'b110, 0, 0, "R4 swap neg");
    scan(PAT4, 4'd4, 2, 3, "R5 scan3");
    smp(0, 14'd11, 14'h3FF0, 3'b011, 0, 0, "R3 both sub");
    smp(3, 14'd5, 14'd5, 3'b011, 0, 0, "R3 sub pos");
    scan(PAT4, 4'd4, 3, 4, "R5 scan4");
    smp(0, 14'd20, 14'd30, 3'b101, 0, 0, "R3 swap imsub");
    scan(PAT4, 4'd4, 0, 5, "R5 wrap");
    smp(1, 14'd40, 14'h3FFE, 3'b000, 0, 0, "R3 add add");
  endtask

  task automatic t_capture();
    scan(PAT4, 4'd4, 1, 6, "R7 scan6");
    @(negedge clk); pattern_i = '0; line_count_i = 4'd1;
    smp(0, 14'd7, 14'd9, 3'b110, 0, 0, "R7 old line kept");
    smp(5, 14'd123, 14'h3F00, 3'b110, 0, 1, "R8 timed");
  endtask

  task automatic t_overrun();
    preload(7, 32'h12345678, 32'h9ABCDEF0);
    exp_re[6] = exp_re[6] + sx(14'd2);   // line 110: re uses im input, subtracted
    exp_re[6] = exp_re[6] - sx(14'd2) - sx(14'd4);
    exp_im[6] = exp_im[6] + sx(14'd1);
    @(negedge clk);
    smp_valid_i = 1'b1; smp_idx_i = 6; smp_re_i = 14'd1; smp_im_i = 14'd4;
    @(negedge clk);
    smp_idx_i = 7; smp_re_i = 14'd8; smp_im_i = 14'd8;
    #1 chk("R9 dropped read", 32'(mem_rd_o), 0);
    @(negedge clk); smp_valid_i = 1'b0;
    chk("R9 err set", 32'(ovr_err_o), 1);
    @(negedge clk);
    chk("R9 first written", mem_re[6], exp_re[6]);
    chk("R9 first written im", mem_im[6], exp_im[6]);
    @(negedge clk);
    chk("R9 dropped no write", mem_re[7], 32'h12345678);
    chk("R9 err sticky", 32'(ovr_err_o), 1);
    do_clear();
    chk("R13 err cleared", 32'(ovr_err_o), 0);
    chk("R13 count cleared", 32'(scan_cnt_o), 0);
  endtask

  task automatic t_wrap();
    preload(8, 32'hAAAAAAAA, 32'hBBBBBBBB);
    scan(30'h0, 4'd1, 0, 1, "R13 first after clear");
    smp(8, 14'd1, 14'd2, 3'b000, 1, 0, "R13 overwrite");
    preload(8, 32'h7FFFFFFF, 32'h80000000);
    scan(30'h0, 4'd1, 0, 2, "R6 single line");
    smp(8, 14'd1, 14'h3FFF, 3'b000, 0, 0, "R12 wrap");
    chk("R12 re value", mem_re[8], 32'h80000000);
    chk("R12 im value", mem_im[8], 32'h7FFFFFFF);
  endtask

  task automatic t_linecount();
    do_clear();
    for (int s = 1; s <= 3; s++) scan(PAT4, 4'd0, 0, s, "R6 count zero");
    do_clear();
    for (int s = 1; s <= 10; s++) scan(PAT4, 4'd15, s - 1, s, "R6 count above max");
    scan(PAT4, 4'd15, 0, 11, "R6 wrap at ten");
    scan(PAT4, 4'd15, 1, 12, "R10 reach max");
    scan(PAT4, 4'd15, 1, 12, "R10 start ignored");
  endtask

  initial begin
    t_reset();
    t_presample();
    t_first_and_accum();
    t_capture();
    t_overrun();
    t_wrap();
    t_linecount();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule